// File: doc/BRIEF.md
# Line-Interface Interrupt Status Register

This block gathers six event sources from a digital subscriber line transceiver into one 8-bit, read-only interrupt status register. Each source has its own capture rule. Three sources are groups of status levels that raise their bit whenever any member changes value. One source is a pair of active-low block-error flags. Two sources are one-cycle strobes that mark the first 2B+D data of a receive or transmit superframe. Each capture goes into a sticky bit. A single active-high interrupt request is raised while any sticky bit is set.

The processor reads the register over a simple 8-bit bus, using a read strobe and an address. A read at the register's address returns the bits in the same cycle and clears all of them at the clock edge that ends the read. A capture that arrives in the same cycle as that read is not lost: the read returns the value from before the capture, and the new bit stays set. A read at any other address returns zero and leaves the bits alone.

Top module: `lirq_status_top`

## Requirements
- R1: While the synchronous active-low reset is applied, all six sticky bits are 0, `irq` is 0, and a read at the register address returns 0x00.
- R2: A read with `bus_rd`=1 and `bus_addr`=0x13 returns the bits in the same cycle, in this layout: bit 5 transmit superframe, bit 4 receive superframe, bit 3 other-status change, bit 2 block error, bit 1 activation change, bit 0 message-state change. Bits 7 and 6 always read 0.
- R3: A read at 0x13 clears every bit at the clock edge that ends it. A read at any other address returns 0x00 and clears nothing.
- R4: When a capture condition and a read at 0x13 happen in the same cycle, the read returns the value from before the capture, and the captured bit is 1 afterwards.
- R5: Bit 0 sets in any cycle in which `eoc_state` differs from its value in the previous cycle.
- R6: Bit 1 sets when `act_rx` or `act_tx` differs from its value in the previous cycle.
- R7: Bit 2 sets in every cycle in which `ne_be_n` or `fe_be_n` is 0. Both flags are active low.
- R8: Bit 3 sets when any of `oof`, `uoa`, `aib` or the bits of `rsv_stat` differs from its value in the previous cycle.
- R9: Bit 4 sets in any cycle with `rx_sf_strobe`=1. Bit 5 sets in any cycle with `tx_sf_strobe`=1.
- R10: `irq` is 1 exactly when at least one of the six bits is 1.
- R11: In the first cycle after reset is released, no change is flagged. Status levels that were present during reset only become the reference values for later comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eoc_state | input | EOC_W | Received operations-channel message state |
| act_rx | input | 1 | Receive-side activation status |
| act_tx | input | 1 | Transmit-side activation status |
| ne_be_n | input | 1 | Near-end block error, active low |
| fe_be_n | input | 1 | Far-end block error, active low |
| oof | input | 1 | Out-of-frame status |
| uoa | input | 1 | Unable-to-activate status |
| aib | input | 1 | Alarm-indication status |
| rsv_stat | input | RSV_W | Reserved line status bits |
| rx_sf_strobe | input | 1 | Receive superframe boundary strobe |
| tx_sf_strobe | input | 1 | Transmit superframe boundary strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Read address |
| bus_rdata | output | DW | Read data, valid in the same cycle as the read |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench goes after a capture that lands in the same cycle as a clearing read. A design that lets the clear win would drop that event without any sign. It also checks reads at a neighbouring address, where a loose address decode would clear bits or return data. The first cycle after reset is covered: a design without a reference-priming step would report a spurious change for any status level that was held during reset. Finally, a block-error flag is held low across several reads, which catches a design that treats the flag as an edge rather than a level and so lets the bit stay clear while the error is still present.

// File: rtl/lirq_pkg.sv
// Package: shared bit positions and widths for the line-interface interrupt
// status register. Assumes the six-bit layout below is decoded by software.
package lirq_pkg;
    localparam int NUM_SRC  = 6;
    localparam int BIT_EOC  = 0;
    localparam int BIT_ACT  = 1;
    localparam int BIT_BERR = 2;
    localparam int BIT_OTH  = 3;
    localparam int BIT_RXSF = 4;
    localparam int BIT_TXSF = 5;
endpackage

// File: rtl/lirq_chg_det.sv
// Change detector: flags a cycle in which any bit of a status group differs
// from its registered copy taken in the previous cycle. Assumes the inputs are
// synchronous to clk. The first cycle after reset only primes the reference.
module lirq_chg_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic         chg
);
    logic [W-1:0] prev_q;
    logic         primed_q;

    // Purpose: keep last cycle's value and note that a reference exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= sig;
            primed_q <= 1'b1;
        end
    end

    // Purpose: raise chg on any difference once primed.
    always_comb chg = primed_q && (sig != prev_q);

    // R11: no change is reported in the cycle right after reset.
    a_r11_no_flag_unprimed: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !chg);
endmodule

// File: rtl/lirq_sticky.sv
// Sticky bit bank: each bit sets on its capture pulse and clears on a
// register read. Set takes priority over clear so no event is lost.
module lirq_sticky #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         rd_clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: hold one event until read; a new capture wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)         q[i] <= 1'b0;
            else if (set[i])    q[i] <= 1'b1;
            else if (rd_clr)    q[i] <= 1'b0;
        end

        // R4: a capture always leaves the bit set.
        a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
        // R3: a read without a capture clears the bit.
        a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !set[i]) |=> !q[i]);
        // R3: with no capture and no read the bit holds.
        a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_clr && !set[i]) |=> $stable(q[i]));
    end
endmodule

// File: rtl/lirq_rd_port.sv
// Read port: decodes the register address, returns the sticky bits
// zero-extended to the bus width and produces the clear-on-read pulse.
// Assumes a read is a single-cycle strobe.
module lirq_rd_port #(
    parameter int              AW       = 8,
    parameter int              DW       = 8,
    parameter int              N        = 6,
    parameter logic [AW-1:0]   REG_ADDR = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bits,
    output logic          hit,
    output logic [DW-1:0] rdata
);
    localparam int PAD = DW - N;

    // Purpose: address decode of the read strobe.
    always_comb hit = bus_rd && (bus_addr == REG_ADDR);

    // Purpose: drive read data only for a matching read.
    always_comb rdata = hit ? {{PAD{1'b0}}, bits} : '0;

    // R2: unused upper bits never read as 1.
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:N] == '0);
    // R3: reads elsewhere return zero.
    a_r3_other_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (rdata == '0));
endmodule

// File: rtl/lirq_status_top.sv
// Line-interface interrupt status register: six capture rules feed sticky
// bits that a processor reads and clears; irq is the OR of the bits.
// Assumes all event inputs are synchronous to clk.
module lirq_status_top
    import lirq_pkg::*;
#(
    parameter int            EOC_W    = 8,
    parameter int            RSV_W    = 4,
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] REG_ADDR = 8'h13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EOC_W-1:0] eoc_state,
    input  logic             act_rx,
    input  logic             act_tx,
    input  logic             ne_be_n,
    input  logic             fe_be_n,
    input  logic             oof,
    input  logic             uoa,
    input  logic             aib,
    input  logic [RSV_W-1:0] rsv_stat,
    input  logic             rx_sf_strobe,
    input  logic             tx_sf_strobe,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq
);
    localparam int OTH_W = 3 + RSV_W;

    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] bits;
    logic               chg_eoc, chg_act, chg_oth, rd_hit;

    lirq_chg_det #(.W(EOC_W)) u_eoc_det (
        .clk(clk), .rst_n(rst_n), .sig(eoc_state), .chg(chg_eoc));

    lirq_chg_det #(.W(2)) u_act_det (
        .clk(clk), .rst_n(rst_n), .sig({act_tx, act_rx}), .chg(chg_act));

    lirq_chg_det #(.W(OTH_W)) u_oth_det (
        .clk(clk), .rst_n(rst_n), .sig({oof, uoa, aib, rsv_stat}), .chg(chg_oth));

    // Purpose: assemble per-bit capture conditions in register layout.
    always_comb begin
        set_vec           = '0;
        set_vec[BIT_EOC]  = chg_eoc;
        set_vec[BIT_ACT]  = chg_act;
        set_vec[BIT_BERR] = !ne_be_n || !fe_be_n;
        set_vec[BIT_OTH]  = chg_oth;
        set_vec[BIT_RXSF] = rx_sf_strobe;
        set_vec[BIT_TXSF] = tx_sf_strobe;
    end

    lirq_sticky #(.N(NUM_SRC)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set(set_vec), .rd_clr(rd_hit), .q(bits));

    lirq_rd_port #(.AW(AW), .DW(DW), .N(NUM_SRC), .REG_ADDR(REG_ADDR)) u_rd (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bits(bits), .hit(rd_hit), .rdata(bus_rdata));

    // Purpose: combined interrupt request.
    always_comb irq = |bits;

    // R5: a message-state change after priming sets bit 0.
    a_r5_eoc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && eoc_state != $past(eoc_state)) |=> bits[BIT_EOC]);
    // R6: an activation status change after priming sets bit 1.
    a_r6_act_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && {act_tx, act_rx} != $past({act_tx, act_rx})) |=> bits[BIT_ACT]);
    // R7: a low block-error flag sets bit 2.
    a_r7_berr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!ne_be_n || !fe_be_n) |=> bits[BIT_BERR]);
    // R9: superframe strobes set bits 4 and 5.
    a_r9_rxsf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sf_strobe |=> bits[BIT_RXSF]);
    a_r9_txsf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sf_strobe |=> bits[BIT_TXSF]);
    // R10: irq can only rise after some capture condition.
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_vec != '0));
endmodule

// File: tb/lirq_status_top_bench.sv
`timescale 1ns/1ps
module lirq_status_top_bench;
    localparam int EOC_W = 8;
    localparam int RSV_W = 4;
    localparam logic [7:0] RADDR = 8'h13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [EOC_W-1:0] eoc_state = '0;
    logic act_rx = 0, act_tx = 0, ne_be_n = 1, fe_be_n = 1;
    logic oof = 0, uoa = 0, aib = 0;
    logic [RSV_W-1:0] rsv_stat = '0;
    logic rx_sf_strobe = 0, tx_sf_strobe = 0, bus_rd = 0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_rdata;
    logic irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // model state
    logic [5:0] exp_q = '0;
    logic [EOC_W-1:0] p_eoc = '0;
    logic [1:0] p_act = '0;
    logic [3+RSV_W-1:0] p_oth = '0;
    bit primed = 0;

    always #10 clk = ~clk;

    lirq_status_top u_lirq_status_top (
        .clk(clk), .rst_n(rst_n), .eoc_state(eoc_state), .act_rx(act_rx),
        .act_tx(act_tx), .ne_be_n(ne_be_n), .fe_be_n(fe_be_n), .oof(oof),
        .uoa(uoa), .aib(aib), .rsv_stat(rsv_stat), .rx_sf_strobe(rx_sf_strobe),
        .tx_sf_strobe(tx_sf_strobe), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .irq(irq));

    function automatic string tag_of(logic [7:0] d);
        if (d[7:6] != 0) return "R2";
        if (d[0]) return "R5";
        if (d[1]) return "R6";
        if (d[2]) return "R7";
        if (d[3]) return "R8";
        if (d[5:4] != 0) return "R9";
        return "R3";
    endfunction

    function automatic logic [5:0] calc_set();
        logic [5:0] s;
        s[0] = primed && (eoc_state != p_eoc);
        s[1] = primed && ({act_tx, act_rx} != p_act);
        s[2] = !ne_be_n || !fe_be_n;
        s[3] = primed && ({oof, uoa, aib, rsv_stat} != p_oth);
        s[4] = rx_sf_strobe;
        s[5] = tx_sf_strobe;
        return s;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Inputs already set after a negedge; check outputs, advance model, next cycle.
    task automatic step(string tag);
        logic hit;
        logic [7:0] er;
        #1;
        hit = bus_rd && (bus_addr == RADDR);
        er  = hit ? {2'b00, exp_q} : 8'h00;
        check((tag == "auto") ? tag_of(bus_rdata ^ er) : tag, bus_rdata, er);
        check((tag == "auto") ? "R10" : tag, {7'b0, irq}, {7'b0, |exp_q});
        if (!rst_n) begin
            exp_q = '0; p_eoc = '0; p_act = '0; p_oth = '0; primed = 0;
        end else begin
            exp_q = calc_set() | (exp_q & ~{6{hit}});
            p_eoc = eoc_state; p_act = {act_tx, act_rx};
            p_oth = {oof, uoa, aib, rsv_stat}; primed = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        bus_rd = 0; rx_sf_strobe = 0; tx_sf_strobe = 0; ne_be_n = 1; fe_be_n = 1;
    endtask

    task automatic rd(logic [7:0] a);
        bus_rd = 1; bus_addr = a;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state, including a read during reset
        rd(RADDR); tx_sf_strobe = 1; step("R1");
        step("R1");
        // R11: levels held during reset must not flag a change
        idle(); eoc_state = 8'h5A; act_rx = 1; oof = 1; step("R11");
        rst_n = 1; step("R11");
        step("R11");
        rd(RADDR); step("R11");
        // R5: message-state change sets bit 0 (0x01), then R3 clear
        idle(); eoc_state = 8'h3C; step("R5");
        rd(RADDR); step("R5");
        rd(RADDR); step("R3");
        // R4: capture in same cycle as read
        idle(); rd(RADDR); tx_sf_strobe = 1; step("R4");
        idle(); rd(RADDR); step("R4");
        // R3: read at a neighbouring address neither clears nor returns data
        idle(); rx_sf_strobe = 1; step("R9");
        idle(); rd(8'h12); step("R3");
        rd(8'h14); step("R3");
        rd(RADDR); step("R3");
        // R7: held block error keeps re-setting across reads
        idle(); fe_be_n = 0; rd(RADDR); step("R7");
        rd(RADDR); step("R7");
        rd(RADDR); step("R7");
        idle(); rd(RADDR); step("R7");
        idle(); rd(RADDR); step("R7");
        // R6, R8: single-bit status changes
        idle(); act_tx = 1; step("R6");
        rd(RADDR); step("R6");
        idle(); rsv_stat[2] = 1; step("R8");
        rd(RADDR); step("R8");
        idle(); uoa = 1; aib = 1; step("R8");
        rd(RADDR); step("R8");
        idle(); step("R2");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) eoc_state = EOC_W'($urandom);
            if ($urandom_range(9) == 0) act_rx = ~act_rx;
            if ($urandom_range(9) == 0) act_tx = ~act_tx;
            ne_be_n = ($urandom_range(15) != 0);
            fe_be_n = ($urandom_range(15) != 0);
            if ($urandom_range(15) == 0) oof = ~oof;
            if ($urandom_range(19) == 0) uoa = ~uoa;
            if ($urandom_range(19) == 0) aib = ~aib;
            if ($urandom_range(19) == 0) rsv_stat = RSV_W'($urandom);
            rx_sf_strobe = ($urandom_range(11) == 0);
            tx_sf_strobe = ($urandom_range(11) == 0);
            bus_rd = ($urandom_range(2) == 0);
            bus_addr = ($urandom_range(9) < 7) ? RADDR : 8'($urandom);
            if (i == 2000) rst_n = 0;
            if (i == 2003) rst_n = 1;
            step("auto");
        end
        idle(); rd(RADDR); step("auto");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule